// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital controller for an ADC front end that has two sample-and-hold stages. A timer start-of-conversion pulse starts a run. The controller then walks a slot pointer through a programmed list of conversion slots. Each slot holds a channel selector k. For that slot the front end samples input Ak and input Bk in the same acquisition window, the converter digitises both samples, and the controller stores the pair as two adjacent entries of a result register file.

The sequencer runs in start/stop fashion. After the last programmed slot it stops and raises a done status. It ignores further trigger pulses until software pulses a pointer reset. When interrupts are enabled, the end of every run sets a sticky interrupt flag, and a software clear strobe drops it. The converter is modelled as a handshake of fixed latency: a one-cycle start pulse, then a completion `CONV_LAT` cycles later, when both codes are captured.

Top module: `simsamp_seq`

## Requirements
- R1: A run starts only when `cfg_trig_en`=1 and `soc_pulse`=1 are sampled at an edge while the block is idle with `seq_done`=0. `busy` is 1 after that edge. No other condition starts a run.
- R2: Slot k uses selector `cfg_chan_list[4k+3:4k]`, which appears on `sh_chan`. `sh_sample` is high for `cfg_acq_len`+1 cycles in every slot.
- R3: A run has `cfg_last_slot`+1 slots. `busy` stays high for exactly (`cfg_last_slot`+1)·(`cfg_acq_len`+1+`CONV_LAT`) cycles.
- R4: Slot k writes its A code to result index 2k and its B code to index 2k+1. A run leaves all higher indices untouched.
- R5: Each 12-bit code is stored left-justified, so `rd_data` = code·16 with the low 4 bits zero. `rd_data` shows the entry addressed by `rd_idx` in the same cycle.
- R6: After the last slot, `seq_done`=1 and `slot_ptr` = `cfg_last_slot`+1. Both hold, and triggers are ignored (`busy` stays 0, results unchanged), until `sw_seq_reset`.
- R7: `sw_seq_reset` returns `slot_ptr` to 0, clears `seq_done` and aborts a run in progress. It wins over a trigger in the same cycle.
- R8: When `cfg_int_en`=1, the end of a run sets `irq_flag`. The flag stays set until `sw_int_clear`. If the set and the clear fall in the same cycle, the flag stays set. With `cfg_int_en`=0 the flag is never set.
- R9: `conv_start` is a one-cycle pulse that occurs exactly once per slot, after that slot's acquisition window.
- R10: Synchronous active-high `rst` clears `busy`, `seq_done`, `irq_flag`, `slot_ptr` and every result entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trig_en | input | 1 | Timer trigger enable |
| cfg_int_en | input | 1 | End-of-run interrupt enable |
| cfg_last_slot | input | 3 | Index of the last slot (slots = value+1) |
| cfg_acq_len | input | 4 | Acquisition window minus one, in clocks |
| cfg_chan_list | input | 32 | Channel selector of each slot, 4 bits per slot |
| soc_pulse | input | 1 | Start-of-conversion pulse from the timer |
| sw_seq_reset | input | 1 | Software pointer reset strobe |
| sw_int_clear | input | 1 | Software interrupt clear strobe |
| adc_code_a | input | 12 | Converted code of the A sample |
| adc_code_b | input | 12 | Converted code of the B sample |
| rd_idx | input | 4 | Result index to read |
| rd_data | output | 16 | Left-justified result at `rd_idx` |
| sh_sample | output | 1 | Acquisition window (both holds tracking) |
| sh_chan | output | 4 | Channel pair selector of the current slot |
| conv_start | output | 1 | Converter start pulse |
| busy | output | 1 | Run in progress |
| seq_done | output | 1 | Run finished, waiting for pointer reset |
| irq_flag | output | 1 | Sticky end-of-run interrupt flag |
| slot_ptr | output | 4 | Current slot pointer |

## Verification
Two pairs of events can land on the same clock edge. The first is the edge on which the last conversion finishes, which sets the interrupt flag, against a software clear of that flag. The second is a trigger pulse against a pointer reset. The bench derives the end-of-run edge from R3 and raises `sw_int_clear` so that the design samples it on that edge; the flag must then read 1. For the second pair it drives `soc_pulse` and `sw_seq_reset` together and expects the block to stay idle with the pointer at 0.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  localparam int CODE_W = 12;
  localparam int RES_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;

  // Place a converter code at the top of a result word.
  function automatic logic [RES_W-1:0] left_justify(input logic [CODE_W-1:0] code);
    return {code, {(RES_W-CODE_W){1'b0}}};
  endfunction

  // Cycles one slot occupies: acquisition window plus converter latency.
  function automatic int slot_cycles(input int acq_setting, input int conv_lat);
    return acq_setting + 1 + conv_lat;
  endfunction
endpackage

// File: rtl/simsamp_slot_fsm.sv
module simsamp_slot_fsm
  import simsamp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CH_W      = 4,
  parameter int ACQ_W     = 4,
  parameter int CONV_LAT  = 13,
  localparam int SEL_W    = $clog2(NUM_SLOTS),
  localparam int PTR_W    = SEL_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig_en,
  input  logic                      soc,
  input  logic                      ptr_reset,
  input  logic [SEL_W-1:0]          last_slot,
  input  logic [ACQ_W-1:0]          acq_len,
  input  logic [NUM_SLOTS*CH_W-1:0] chan_list,
  output logic                      busy,
  output logic                      done_stat,
  output logic [PTR_W-1:0]          ptr,
  output logic [SEL_W-1:0]          cur_slot,
  output logic                      sample_win,
  output logic [CH_W-1:0]           cur_chan,
  output logic                      cv_start,
  output logic                      cv_done,
  output logic                      run_end
);
  localparam int LAT_W = $clog2(CONV_LAT + 1);
  localparam int CNT_W = (ACQ_W > LAT_W) ? ACQ_W : LAT_W;

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             at_last;

  assign cur_slot   = ptr[SEL_W-1:0];
  assign at_last    = (cur_slot == last_slot);
  assign accept     = (state == ST_IDLE) && !done_stat && trig_en && soc && !ptr_reset;
  assign busy       = (state != ST_IDLE);
  assign sample_win = (state == ST_ACQ);
  assign cur_chan   = chan_list[cur_slot*CH_W +: CH_W];
  assign cv_start   = (state == ST_CONV) && (cnt == '0);
  assign cv_done    = (state == ST_CONV) && (cnt == CNT_W'(CONV_LAT - 1));
  assign run_end    = cv_done && at_last && !ptr_reset;

  always_ff @(posedge clk) begin
    if (rst || ptr_reset) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ptr       <= '0;
      done_stat <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_ACQ;
            cnt   <= '0;
          end
        end
        ST_ACQ: begin
          if (cnt == CNT_W'(acq_len)) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CONV: begin
          if (cv_done) begin
            ptr <= ptr + PTR_W'(1);
            cnt <= '0;
            if (at_last) begin
              state     <= ST_IDLE;
              done_stat <= 1'b1;
            end else begin
              state <= ST_ACQ;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/simsamp_result_file.sv
module simsamp_result_file
  import simsamp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SEL_W    = $clog2(NUM_SLOTS),
  localparam int RES_N    = 2 * NUM_SLOTS,
  localparam int IDX_W    = $clog2(RES_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_slot,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [RES_W-1:0]  rd_data
);
  logic [RES_W-1:0] entry [RES_N];

  for (genvar i = 0; i < RES_N; i++) begin : g_entry
    localparam int OWNER = i / 2;
    localparam bit IS_B  = (i % 2) == 1;
    logic [RES_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_slot == SEL_W'(OWNER))) begin
        q <= IS_B ? left_justify(code_b) : left_justify(code_a);
      end
    end
    assign entry[i] = q;
  end

  assign rd_data = entry[rd_idx];
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
  import simsamp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CH_W      = 4,
  parameter int ACQ_W     = 4,
  parameter int CONV_LAT  = 13,
  localparam int SEL_W    = $clog2(NUM_SLOTS),
  localparam int PTR_W    = SEL_W + 1,
  localparam int IDX_W    = $clog2(2 * NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_trig_en,
  input  logic                      cfg_int_en,
  input  logic [SEL_W-1:0]          cfg_last_slot,
  input  logic [ACQ_W-1:0]          cfg_acq_len,
  input  logic [NUM_SLOTS*CH_W-1:0] cfg_chan_list,
  input  logic                      soc_pulse,
  input  logic                      sw_seq_reset,
  input  logic                      sw_int_clear,
  input  logic [CODE_W-1:0]         adc_code_a,
  input  logic [CODE_W-1:0]         adc_code_b,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [RES_W-1:0]          rd_data,
  output logic                      sh_sample,
  output logic [CH_W-1:0]           sh_chan,
  output logic                      conv_start,
  output logic                      busy,
  output logic                      seq_done,
  output logic                      irq_flag,
  output logic [PTR_W-1:0]          slot_ptr
);
  logic             conv_done;
  logic             seq_end;
  logic [SEL_W-1:0] cur_slot;

  simsamp_slot_fsm #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .ACQ_W(ACQ_W), .CONV_LAT(CONV_LAT)
  ) u_fsm (
    .clk(clk), .rst(rst), .trig_en(cfg_trig_en), .soc(soc_pulse),
    .ptr_reset(sw_seq_reset), .last_slot(cfg_last_slot), .acq_len(cfg_acq_len),
    .chan_list(cfg_chan_list), .busy(busy), .done_stat(seq_done), .ptr(slot_ptr),
    .cur_slot(cur_slot), .sample_win(sh_sample), .cur_chan(sh_chan),
    .cv_start(conv_start), .cv_done(conv_done), .run_end(seq_end)
  );

  simsamp_result_file #(.NUM_SLOTS(NUM_SLOTS)) u_res (
    .clk(clk), .rst(rst), .wr_en(conv_done && !sw_seq_reset), .wr_slot(cur_slot),
    .code_a(adc_code_a), .code_b(adc_code_b), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // A new end-of-run event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
    end else if (seq_end && cfg_int_en) begin
      irq_flag <= 1'b1;
    end else if (sw_int_clear) begin
      irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/simsamp_checker.sv
module simsamp_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_trig_en,
  input logic       cfg_int_en,
  input logic       soc_pulse,
  input logic       sw_seq_reset,
  input logic       sw_int_clear,
  input logic       sh_sample,
  input logic       conv_start,
  input logic       conv_done,
  input logic       seq_end,
  input logic       busy,
  input logic       seq_done,
  input logic       irq_flag,
  input logic [3:0] slot_ptr
);
  AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(soc_pulse && cfg_trig_en)); // R1
  AST_SAMPLE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    sh_sample |-> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !busy); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (seq_done && !sw_seq_reset) |=> seq_done); // R6
  AST_PTR_RESET: assert property (@(posedge clk) disable iff (rst)
    sw_seq_reset |=> (slot_ptr == 4'd0 && !busy && !seq_done)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !sw_int_clear) |=> irq_flag); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(seq_end && cfg_int_en)); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R9
  AST_DONE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> (busy && !sh_sample)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!busy && !seq_done && !irq_flag && slot_ptr == 4'd0)); // R10
endmodule

bind simsamp_seq simsamp_checker u_chk (
  .clk(clk), .rst(rst), .cfg_trig_en(cfg_trig_en), .cfg_int_en(cfg_int_en),
  .soc_pulse(soc_pulse), .sw_seq_reset(sw_seq_reset), .sw_int_clear(sw_int_clear),
  .sh_sample(sh_sample), .conv_start(conv_start), .conv_done(conv_done),
  .seq_end(seq_end), .busy(busy), .seq_done(seq_done), .irq_flag(irq_flag),
  .slot_ptr(slot_ptr)
);

// File: tb/simsamp_seq_tb.sv
`timescale 1ns/1ps
module simsamp_seq_tb;
  localparam int LAT = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_trig_en = 1'b0, cfg_int_en = 1'b0;
  logic [2:0]  cfg_last_slot = '0;
  logic [3:0]  cfg_acq_len = '0;
  logic [31:0] cfg_chan_list = '0;
  logic        soc_pulse = 1'b0, sw_seq_reset = 1'b0, sw_int_clear = 1'b0;
  logic [11:0] adc_code_a, adc_code_b;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        sh_sample, conv_start, busy, seq_done, irq_flag;
  logic [3:0]  sh_chan, slot_ptr;
  logic [7:0]  salt = 8'h00;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  // Analog front-end stand-in: codes depend on the selected pair.
  assign adc_code_a = {sh_chan, salt};
  assign adc_code_b = {~sh_chan, ~salt};

  simsamp_seq u_dut (
    .clk(clk), .rst(rst), .cfg_trig_en(cfg_trig_en), .cfg_int_en(cfg_int_en),
    .cfg_last_slot(cfg_last_slot), .cfg_acq_len(cfg_acq_len), .cfg_chan_list(cfg_chan_list),
    .soc_pulse(soc_pulse), .sw_seq_reset(sw_seq_reset), .sw_int_clear(sw_int_clear),
    .adc_code_a(adc_code_a), .adc_code_b(adc_code_b), .rd_idx(rd_idx), .rd_data(rd_data),
    .sh_sample(sh_sample), .sh_chan(sh_chan), .conv_start(conv_start), .busy(busy),
    .seq_done(seq_done), .irq_flag(irq_flag), .slot_ptr(slot_ptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_results(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(req, int'(rd_data), int'(model[i]));
    end
  endtask

  task automatic pulse_seq_reset();
    @(negedge clk); sw_seq_reset = 1'b1;
    @(negedge clk); sw_seq_reset = 1'b0;
  endtask

  task automatic pulse_int_clear();
    @(negedge clk); sw_int_clear = 1'b1;
    @(negedge clk); sw_int_clear = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 busy after reset", busy, 0);
    chk("R10 done after reset", seq_done, 0);
    chk("R10 irq after reset", irq_flag, 0);
    chk("R10 pointer after reset", slot_ptr, 0);
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    check_results("R10 results cleared");
  endtask

  task automatic t_run(input int last, input int acq, input logic [31:0] chans,
                       input bit ien, input logic [7:0] s);
    int cyc = 0, samp = 0, starts = 0, chan_bad = 0;
    @(negedge clk);
    cfg_trig_en = 1'b1; cfg_int_en = ien; cfg_last_slot = 3'(last);
    cfg_acq_len = 4'(acq); cfg_chan_list = chans; salt = s;
    soc_pulse = 1'b1;
    @(negedge clk);
    soc_pulse = 1'b0;
    chk("R1 busy after accepted trigger", busy, 1);
    while (busy && cyc < 5000) begin
      cyc++;
      if (sh_sample) begin
        samp++;
        if (sh_chan != chans[starts*4 +: 4]) chan_bad++;
      end
      if (conv_start) starts++;
      @(negedge clk);
    end
    chk("R3 busy length", cyc, (last + 1) * (acq + 1 + LAT));
    chk("R2 acquisition cycles", samp, (last + 1) * (acq + 1));
    chk("R2 channel per slot", chan_bad, 0);
    chk("R9 converter starts", starts, last + 1);
    chk("R6 done raised", seq_done, 1);
    chk("R6 pointer parked", slot_ptr, last + 1);
    chk("R8 irq versus enable", irq_flag, int'(ien));
    for (int k = 0; k <= last; k++) begin
      model[2*k]   = {chans[k*4 +: 4], s, 4'h0};
      model[2*k+1] = {~chans[k*4 +: 4], ~s, 4'h0};
    end
    check_results("R4 R5 result placement");
  endtask

  task automatic t_ignored_trigger();
    @(negedge clk); salt = 8'h77; soc_pulse = 1'b1;
    @(negedge clk); soc_pulse = 1'b0;
    chk("R6 trigger ignored while done", busy, 0);
    repeat (20) @(negedge clk);
    chk("R6 still idle", busy, 0);
    chk("R6 pointer held", slot_ptr, int'(cfg_last_slot) + 1);
    check_results("R6 results unchanged");
  endtask

  task automatic t_trig_disabled();
    pulse_seq_reset();
    chk("R7 pointer back to zero", slot_ptr, 0);
    chk("R7 done cleared", seq_done, 0);
    @(negedge clk); cfg_trig_en = 1'b0; soc_pulse = 1'b1;
    @(negedge clk); soc_pulse = 1'b0;
    chk("R1 no start when trigger disabled", busy, 0);
    cfg_trig_en = 1'b1;
  endtask

  task automatic t_abort_and_priority();
    @(negedge clk); cfg_acq_len = 4'd0; soc_pulse = 1'b1;
    @(negedge clk); soc_pulse = 1'b0;
    repeat (5) @(negedge clk);
    sw_seq_reset = 1'b1;
    @(negedge clk); sw_seq_reset = 1'b0;
    chk("R7 abort stops run", busy, 0);
    chk("R7 abort pointer", slot_ptr, 0);
    soc_pulse = 1'b1; sw_seq_reset = 1'b1;
    @(negedge clk); soc_pulse = 1'b0; sw_seq_reset = 1'b0;
    chk("R7 reset beats trigger", busy, 0);
    repeat (3) @(negedge clk);
    chk("R7 stays idle", busy, 0);
    check_results("R7 abort wrote nothing");
  endtask

  task automatic t_irq_collision();
    int total = 2 * (0 + 1 + LAT);
    @(negedge clk);
    cfg_int_en = 1'b1; cfg_last_slot = 3'd1; cfg_acq_len = 4'd0;
    cfg_chan_list = 32'h0000_0032; salt = 8'h5A;
    soc_pulse = 1'b1;
    @(negedge clk); soc_pulse = 1'b0;
    chk("R8 irq clear before collision", irq_flag, 0);
    repeat (total - 1) @(negedge clk);
    sw_int_clear = 1'b1;
    @(negedge clk); sw_int_clear = 1'b0;
    chk("R8 set wins over same-cycle clear", irq_flag, 1);
    repeat (4) @(negedge clk);
    chk("R8 flag sticky", irq_flag, 1);
    pulse_int_clear();
    chk("R8 clear drops flag", irq_flag, 0);
    for (int k = 0; k < 2; k++) begin
      model[2*k]   = {cfg_chan_list[k*4 +: 4], salt, 4'h0};
      model[2*k+1] = {~cfg_chan_list[k*4 +: 4], ~salt, 4'h0};
    end
    check_results("R4 collision run results");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run(7, 0, 32'h7654_3210, 1'b1, 8'hC3);
    t_ignored_trigger();
    chk("R8 irq held through idle", irq_flag, 1);
    pulse_int_clear();
    chk("R8 cleared by software", irq_flag, 0);
    t_trig_disabled();
    t_run(2, 3, 32'h0000_0507, 1'b0, 8'h19);
    pulse_seq_reset();
    t_abort_and_priority();
    t_irq_collision();
    pulse_seq_reset();
    t_run(0, 15, 32'h0000_000F, 1'b1, 8'hE1);
    t_reset();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule